// File: doc/BRIEF.md
# Reversible Binary Counter with Asynchronous Preset

This block is a small binary counter that steps up or down by one on each rising clock edge while its active-low enable is asserted. A single select input sets the direction. An active-low load input forces a parallel data word onto the count at once, with no clock edge needed. The load wins over counting for as long as it is held low, and the count follows the data word during that time. The register width is a parameter, and the default is four bits.

Two indicators report the end of the count range. The terminal flag is decoded combinationally from the current count and the direction. It is high at the all-ones value when counting up and at zero when counting down. The active-low ripple output copies the clock low phase only while the terminal flag is high and the counter is enabled. Several stages can be chained through the ripple output, with each stage's ripple driving the clock of the next.

Top module: `bidir_preset_counter`

## Requirements
- R1: While `load_n` is low, `count` equals `load_val` without waiting for a clock edge, and a rising clock edge during that time does not change it.
- R2: With `load_n` high and `cnt_en_n` high, `count` keeps its value across rising clock edges.
- R3: With `load_n` high, `cnt_en_n` low and `dir_down` = 0, each rising clock edge increments `count` by one.
- R4: With `load_n` high, `cnt_en_n` low and `dir_down` = 1, each rising clock edge decrements `count` by one.
- R5: Counting wraps: up from all ones (15 by default) goes to 0, and down from 0 goes to all ones.
- R6: `term_cnt` is 1 when `dir_down` = 0 and `count` is all ones, or when `dir_down` = 1 and `count` is 0. In every other case it is 0.
- R7: Changing `dir_down` alone updates `term_cnt` without any clock edge.
- R8: `term_cnt` does not depend on `cnt_en_n`.
- R9: `ripple_n` is 0 only while `clk` is low, `term_cnt` is 1 and `cnt_en_n` is 0. It is 1 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock; the count changes on its rising edge |
| cnt_en_n | input | 1 | Count enable, active low |
| dir_down | input | 1 | Direction: 0 counts up, 1 counts down |
| load_n | input | 1 | Asynchronous parallel load, active low |
| load_val | input | W | Value forced onto the count during load |
| count | output | W | Current count |
| term_cnt | output | 1 | Terminal-count flag for the current direction |
| ripple_n | output | 1 | Active-low ripple clock for cascading |

## Verification
The step properties assume that `load_n` does not pulse low between two rising clock edges. Each load is expected to be held low across at least one rising edge, so that the disable clause covers it. They also assume that `cnt_en_n` and `dir_down` change only while the clock is low. The bench drives every input just after a falling edge and holds it through the next rising edge. Nothing is checked until the first load has given the count a defined value, and the bench therefore starts with a load.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic { DIR_UP = 1'b0, DIR_DOWN = 1'b1 } dir_e;
endpackage

// File: rtl/bpc_state.sv
module bpc_state #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         load_n,
  input  logic         cnt_en_n,
  input  bpc_pkg::dir_e dir,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] step_val;

  // next value one step along the selected direction, wrapping at the ends
  function automatic logic [W-1:0] step_count(input logic [W-1:0] cur, input bpc_pkg::dir_e d);
    logic [W-1:0] one;
    one = {{(W-1){1'b0}}, 1'b1};
    return (d == bpc_pkg::DIR_DOWN) ? cur - one : cur + one;
  endfunction

  assign step_val = step_count(cnt_q, dir);

  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n)        cnt_q <= load_val;
    else if (!cnt_en_n) cnt_q <= step_val;
  end

  // data is transparent to the output while the load is held
  assign count_o = load_n ? cnt_q : load_val;
endmodule

// File: rtl/bpc_term.sv
module bpc_term #(
  parameter int W = 4
) (
  input  logic [W-1:0]  count_i,
  input  bpc_pkg::dir_e dir,
  output logic          term_o
);
  function automatic logic at_end(input logic [W-1:0] cur, input bpc_pkg::dir_e d);
    return (d == bpc_pkg::DIR_DOWN) ? (cur == '0) : (cur == '1);
  endfunction

  assign term_o = at_end(count_i, dir);
endmodule

// File: rtl/bpc_ripple.sv
module bpc_ripple (
  input  logic clk,
  input  logic term_i,
  input  logic cnt_en_n,
  output logic ripple_n
);
  logic pass;
  assign pass     = term_i & ~cnt_en_n;
  assign ripple_n = ~(pass & ~clk);
endmodule

// File: rtl/bidir_preset_counter.sv
module bidir_preset_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         cnt_en_n,
  input  logic         dir_down,
  input  logic         load_n,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         term_cnt,
  output logic         ripple_n
);
  bpc_pkg::dir_e dir;
  logic          advance;   // an enabled, unloaded clock edge will step

  assign dir     = bpc_pkg::dir_e'(dir_down);
  assign advance = load_n & ~cnt_en_n;

  bpc_state #(.W(W)) u_state (
    .clk(clk), .load_n(load_n), .cnt_en_n(cnt_en_n), .dir(dir),
    .load_val(load_val), .count_o(count)
  );

  bpc_term #(.W(W)) u_term (.count_i(count), .dir(dir), .term_o(term_cnt));

  bpc_ripple u_ripple (.clk(clk), .term_i(term_cnt), .cnt_en_n(cnt_en_n), .ripple_n(ripple_n));

  bidir_preset_counter_chk #(.W(W)) u_chk (
    .clk(clk), .cnt_en_n(cnt_en_n), .dir_down(dir_down), .load_n(load_n),
    .load_val(load_val), .count(count), .term_cnt(term_cnt),
    .ripple_n(ripple_n), .advance(advance)
  );
endmodule

// File: rtl/bidir_preset_counter_chk.sv
module bidir_preset_counter_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         cnt_en_n,
  input logic         dir_down,
  input logic         load_n,
  input logic [W-1:0] load_val,
  input logic [W-1:0] count,
  input logic         term_cnt,
  input logic         ripple_n,
  input logic         advance
);
  logic armed = 1'b0;
  always_ff @(posedge clk or negedge load_n)
    if (!load_n) armed <= 1'b1;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!armed)
    !load_n |-> count == load_val);  // R1
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!armed || !load_n)
    (load_n && cnt_en_n) |=> $stable(count));  // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!armed || !load_n)
    (advance && !dir_down) |=> count == W'($past(count) + 1'b1));  // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!armed || !load_n)
    (advance && dir_down) |=> count == W'($past(count) - 1'b1));  // R4
  AST_TERM_RANGE: assert property (@(posedge clk) disable iff (!armed)
    term_cnt |-> (count == '0 || count == '1));  // R6
  AST_RIPPLE_QUIET: assert property (@(posedge clk) disable iff (!armed)
    (cnt_en_n || !term_cnt) |-> ripple_n);  // R9
endmodule

// File: tb/bidir_preset_counter_test.sv
`timescale 1ns/1ps
module bidir_preset_counter_test;
  localparam int W = 4;
  localparam int TOP = (1 << W) - 1;

  logic clk = 1'b0;
  logic cnt_en_n = 1'b1, dir_down = 1'b0, load_n = 1'b1;
  logic [W-1:0] load_val = '0;
  logic [W-1:0] count;
  logic term_cnt, ripple_n;

  int total = 0, bad = 0;
  int model = 0;
  bit finished = 0;

  typedef struct { int cnt; bit tc; string tag; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  bidir_preset_counter #(.W(W)) uut (
    .clk(clk), .cnt_en_n(cnt_en_n), .dir_down(dir_down), .load_n(load_n),
    .load_val(load_val), .count(count), .term_cnt(term_cnt), .ripple_n(ripple_n)
  );

  function automatic bit tc_of(int c, bit dn);
    if (dn) return c == 0;
    return c == TOP;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one cycle, check the clock-low phase, queue the post-edge result
  task automatic apply(bit en_n, bit dn, bit ld_n, int val, string tag);
    exp_t e;
    @(negedge clk);
    cnt_en_n = en_n; dir_down = dn; load_n = ld_n; load_val = W'(val);
    #1;
    if (!ld_n) model = val;
    check({tag, " count low phase"}, int'(count), model);
    check({tag, " term R6 R7 R8"}, int'(term_cnt), int'(tc_of(model, dn)));
    check({tag, " ripple low phase R9"}, int'(ripple_n), int'(!(tc_of(model, dn) && !en_n)));
    if (ld_n && !en_n) model = dn ? (model + TOP) % (TOP + 1) : (model + 1) % (TOP + 1);
    e.cnt = model; e.tc = tc_of(model, dn); e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check({e.tag, " count"}, int'(count), e.cnt);
        check({e.tag, " term R6"}, int'(term_cnt), int'(e.tc));
        check({e.tag, " ripple high phase R9"}, int'(ripple_n), 1);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    apply(1, 0, 0, 5, "R1 initial load");
    apply(1, 0, 1, 0, "R2 after load");
    apply(0, 0, 1, 0, "R3 up");
    apply(0, 0, 1, 0, "R3 up");
    apply(1, 0, 1, 0, "R2 hold");
    apply(1, 1, 1, 0, "R2 hold down");
    apply(0, 1, 1, 0, "R4 down");
    apply(0, 0, 0, 14, "R1 load during count");
    apply(0, 0, 1, 0, "R3 to top");
    apply(1, 0, 1, 0, "R8 top disabled");
    apply(1, 1, 1, 0, "R7 dir change clears");
    apply(1, 0, 1, 0, "R7 dir change sets");
    apply(0, 0, 1, 0, "R5 wrap up");
    apply(0, 1, 1, 0, "R5 wrap down");
    apply(0, 1, 0, 1, "R1 load one");
    apply(0, 1, 1, 0, "R4 to zero");
    apply(1, 1, 1, 0, "R8 zero disabled");
    apply(0, 1, 1, 0, "R9 ripple at zero");
    for (int i = 0; i < 20; i++) apply(0, 0, 1, 0, "R3 R5 sweep up");
    for (int i = 0; i < 20; i++) apply(0, 1, 1, 0, "R4 R5 sweep down");
    for (int v = 0; v <= TOP; v += 5) begin
      apply(0, v[0], 0, v, "R1 preset sweep");
      apply(0, v[0], 1, 0, "R3 R4 after preset");
    end
    apply(1, 0, 1, 0, "R2 final hold");
    @(posedge clk); #3;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule